// File: doc/BRIEF.md
# Receive Byte Counter with Frame Length Reporting

This block tracks how many bytes a serial receiver has moved from its shift register into the receive FIFO. Software programs a 16-bit reload value. The counter is preset from that value on any of three software commands (trigger receive DMA, load count, purge receive FIFO) or when the receiver sees an opening flag or sync character. Each frame therefore starts with a fresh count without software having to act.

A nonzero preset enables counting and a zero preset disables it. While enabled, every transferred byte takes one from the count. A byte that arrives after the count has reached zero raises a sticky over-length interrupt, and the count stays at zero. The reload value is the largest frame the receiver accepts, received CRC bytes included. A frame-end pulse captures the ones complement of the current count into a length register for the status block. With an all-ones preset, that captured value is the number of bytes received.

Control is a three-state machine:
- **CNT_OFF**: counting disabled, count at zero.
- **CNT_RUN**: enabled, count nonzero.
- **CNT_DRAINED**: enabled, count exhausted.

The transitions are:
- Any state goes to CNT_OFF on a preset of zero.
- Any state goes to CNT_RUN on a nonzero preset.
- CNT_RUN goes to CNT_DRAINED on a byte that takes the count from 1 to 0.

Top module: `rx_len_counter`

## Requirements
- R1: After reset the remaining count, the frame length and the interrupt are all 0, and the enable flag is 0.
- R2: A one-cycle pulse on any of the four preset sources (trigger, load, purge, opening flag) makes the remaining count equal to the reload input on the next cycle.
- R3: A preset of zero clears the enable flag, and later byte pulses leave the count at 0 and raise no interrupt. A nonzero preset sets the enable flag.
- R4: While the count is nonzero and enabled, each byte pulse lowers the count by exactly 1, on the cycle after the pulse.
- R5: A byte pulse while enabled with a count of 0 sets the interrupt on the next cycle, and the count stays 0.
- R6: The interrupt stays set until a clear strobe. An opening flag does not clear it. If a set and a clear fall in the same cycle, the set wins.
- R7: A frame-end pulse makes the frame length equal to the bitwise inverse of the remaining count as it stood in that cycle, on the next cycle.
- R8: A preset and a byte pulse in the same cycle load the reload value, and that byte is not counted.
- R9: With an all-ones preset followed by N byte pulses, the frame length captured at frame end equals N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_trig_rx_i | input | 1 | Trigger-receive-DMA command strobe |
| cmd_load_cnt_i | input | 1 | Load-count command strobe |
| cmd_purge_rx_i | input | 1 | Purge-receive-FIFO command strobe |
| open_flag_i | input | 1 | Opening flag or sync detected pulse |
| byte_xfer_i | input | 1 | One byte moved into the receive FIFO |
| frame_end_i | input | 1 | Frame completed; capture length |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt |
| reload_val_i | input | 16 | Software reload value |
| count_o | output | 16 | Remaining count, readable at any time |
| frame_len_o | output | 16 | Captured frame length for the status block |
| ovl_irq_o | output | 1 | Sticky over-length interrupt |
| cnt_en_o | output | 1 | Counting enabled |

## Verification
Every result is one register stage behind its stimulus. The count, the enable flag, the interrupt and the frame length all change at the first rising edge after the cycle in which the strobe is high. The bench therefore drives each strobe on a falling edge and drops it on the next falling edge. It compares outputs at that second falling edge, just after the updating edge has passed. Multi-byte sequences apply one byte per cycle and are checked only after the last byte's edge. Cases where a byte is ignored are checked on the same cycle grid, so a stray decrement would show.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    typedef enum logic [1:0] {
        CNT_OFF     = 2'd0,
        CNT_RUN     = 2'd1,
        CNT_DRAINED = 2'd2
    } cnt_state_e;

    localparam int unsigned N_PRESET_SRC = 4;

endpackage

// File: rtl/rxc_preset_sel.sv
module rxc_preset_sel #(
    parameter int unsigned N_SRC = 4
) (
    input  logic [N_SRC-1:0] src_i,
    output logic             preset_o
);
    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < N_SRC; g++) begin : g_or
        assign chain[g+1] = chain[g] | src_i[g];
    end
    assign preset_o = chain[N_SRC];

endmodule

// File: rtl/rxc_count_fsm.sv
module rxc_count_fsm
    import rxc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset_i,
    input  logic [W-1:0] reload_i,
    input  logic         byte_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         irq_o,
    output logic         en_o
);
    localparam logic [W-1:0] ONE = W'(1);

    cnt_state_e   state_q, state_d;
    logic [W-1:0] cnt_q;
    logic         irq_q;
    logic         irq_set;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (preset_i) begin
            state_d = (reload_i == '0) ? CNT_OFF : CNT_RUN;
        end else begin
            unique case (state_q)
                CNT_OFF:     state_d = CNT_OFF;
                CNT_RUN:     if (byte_i && cnt_q == ONE) state_d = CNT_DRAINED;
                CNT_DRAINED: state_d = CNT_DRAINED;
                default:     state_d = CNT_OFF;
            endcase
        end
    end

    assign irq_set = (state_q == CNT_DRAINED) && byte_i && !preset_i;

    // outputs: count and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (preset_i)
                cnt_q <= reload_i;
            else if (state_q == CNT_RUN && byte_i)
                cnt_q <= cnt_q - ONE;
            if (irq_set)
                irq_q <= 1'b1;
            else if (clr_i)
                irq_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign irq_o = irq_q;
    assign en_o  = (state_q != CNT_OFF);

    // R2
    preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (cnt_q == $past(reload_i)));

    // R3
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_OFF) |-> (cnt_q == '0 && !en_o));

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && byte_i && !preset_i) |=> (cnt_q == $past(cnt_q) - ONE));

    // R5
    ovl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_DRAINED && byte_i && !preset_i) |=> (irq_q && cnt_q == '0));

    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr_i) |=> irq_q);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ($past(byte_i) && $past(state_q) == CNT_DRAINED));

endmodule

// File: rtl/rxc_len_latch.sv
module rxc_len_latch #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_end_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] len_o
);
    logic [W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           len_q <= '0;
        else if (frame_end_i) len_q <= ~cnt_i;
    end

    assign len_o = len_q;

    // R7
    len_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_i |=> (len_q == ~$past(cnt_i)));

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(len_q));

endmodule

// File: rtl/rx_len_counter.sv
module rx_len_counter
    import rxc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_trig_rx_i,
    input  logic             cmd_load_cnt_i,
    input  logic             cmd_purge_rx_i,
    input  logic             open_flag_i,
    input  logic             byte_xfer_i,
    input  logic             frame_end_i,
    input  logic             irq_clr_i,
    input  logic [CNT_W-1:0] reload_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] frame_len_o,
    output logic             ovl_irq_o,
    output logic             cnt_en_o
);
    logic                    preset;
    logic [N_PRESET_SRC-1:0] preset_src;
    logic [CNT_W-1:0]        cnt;

    assign preset_src = {open_flag_i, cmd_purge_rx_i, cmd_load_cnt_i, cmd_trig_rx_i};

    rxc_preset_sel #(.N_SRC(N_PRESET_SRC)) u_sel (
        .src_i    (preset_src),
        .preset_o (preset)
    );

    rxc_count_fsm #(.W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_i (preset),
        .reload_i (reload_val_i),
        .byte_i   (byte_xfer_i),
        .clr_i    (irq_clr_i),
        .cnt_o    (cnt),
        .irq_o    (ovl_irq_o),
        .en_o     (cnt_en_o)
    );

    rxc_len_latch #(.W(CNT_W)) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end_i (frame_end_i),
        .cnt_i       (cnt),
        .len_o       (frame_len_o)
    );

    assign count_o = cnt;

endmodule

// File: tb/test_rx_len_counter.sv
module test_rx_len_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0, ldc = 1'b0, purge = 1'b0, oflag = 1'b0;
    logic        bytex = 1'b0, fend = 1'b0, clr = 1'b0;
    logic [15:0] reload = '0;
    logic [15:0] count, flen;
    logic        irq, en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rx_len_counter i_rx_len_counter (
        .clk(clk), .rst_n(rst_n),
        .cmd_trig_rx_i(trig), .cmd_load_cnt_i(ldc), .cmd_purge_rx_i(purge),
        .open_flag_i(oflag), .byte_xfer_i(bytex), .frame_end_i(fend),
        .irq_clr_i(clr), .reload_val_i(reload),
        .count_o(count), .frame_len_o(flen), .ovl_irq_o(irq), .cnt_en_o(en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: strobes set before call are sampled at the next posedge
    task automatic tick();
        @(negedge clk);
        trig = 0; ldc = 0; purge = 0; oflag = 0; bytex = 0; fend = 0; clr = 0;
    endtask

    task automatic preset_with(input int src, input logic [15:0] v);
        reload = v;
        case (src)
            0: trig = 1;
            1: ldc = 1;
            2: purge = 1;
            default: oflag = 1;
        endcase
        tick();
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin
            bytex = 1;
            tick();
        end
    endtask

    task automatic t_reset();
        check("R1 count", count, 0);
        check("R1 len", flen, 0);
        check("R1 irq", irq, 0);
        check("R1 en", en, 0);
    endtask

    task automatic t_sources();
        for (int s = 0; s < 4; s++) begin
            preset_with(s, 16'h0100 + 16'(s) * 16'h11);
            check("R2 preset source", count, 32'h0100 + s * 32'h11);
            check("R3 enable set", en, 1);
        end
    endtask

    task automatic t_zero_disables();
        preset_with(1, 16'h0000);
        check("R3 en cleared", en, 0);
        bytes(3);
        check("R3 count stays 0", count, 0);
        check("R3 no irq", irq, 0);
    endtask

    task automatic t_decrement();
        preset_with(0, 16'd10);
        bytes(1);
        check("R4 one step", count, 9);
        bytes(3);
        check("R4 four steps", count, 6);
    endtask

    task automatic t_overlength();
        preset_with(3, 16'd2);
        bytes(2);
        check("R5 reached zero", count, 0);
        check("R5 no irq at zero", irq, 0);
        check("R5 still enabled", en, 1);
        bytes(1);
        check("R5 irq set", irq, 1);
        check("R5 count held", count, 0);
        bytes(1);
        check("R5 count held again", count, 0);
    endtask

    task automatic t_irq_clear();
        preset_with(3, 16'd50);
        check("R6 flag keeps irq", irq, 1);
        clr = 1;
        tick();
        check("R6 clear", irq, 0);
        preset_with(1, 16'd1);
        bytes(1);
        bytex = 1;
        clr = 1;
        tick();
        check("R6 set beats clear", irq, 1);
        clr = 1;
        tick();
        check("R6 clear after", irq, 0);
    endtask

    task automatic t_priority();
        preset_with(1, 16'd5);
        reload = 16'd8;
        ldc = 1;
        bytex = 1;
        tick();
        check("R8 preset wins", count, 8);
    endtask

    task automatic t_frame_len();
        preset_with(2, 16'd100);
        bytes(7);
        fend = 1;
        tick();
        check("R7 length", flen, {16'h0, ~16'd93});
        bytes(2);
        check("R7 len held", flen, {16'h0, ~16'd93});
    endtask

    task automatic t_all_ones();
        preset_with(3, 16'hFFFF);
        bytes(13);
        fend = 1;
        tick();
        check("R9 all-ones length", flen, 13);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sources();
        t_zero_disables();
        t_decrement();
        t_overlength();
        t_irq_clear();
        t_priority();
        t_frame_len();
        t_all_ones();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule